// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus cycles of a 16-bit processor that reaches a 20-bit address space over one shared set of address/data pins. A client offers a transfer (memory or I/O, read or write, byte or word) together with its address, a two-bit segment-class tag and the write data. The sequencer accepts it and steps through the states T1, T2, T3, any number of wait states and T4, one clock each. It drives the address latch strobe, the read and write strobes, the high-byte enable and the status codes. It also sets the output enables for the shared pins.

The low 16 pins carry the address in T1 and data afterwards. The top four pins carry address bits 19..16 in T1 and a status nibble afterwards. A slow device stretches the transfer by holding `ready` low. An external master can take the bus with `holdReq`. The grant is given only between transfers, and while it lasts every pin group is released.

Top module: `mux_bus_seq`

## Requirements
- R1: In T1, `ale` is 1 for exactly one clock, `busAdOut` equals address bits 15..0 and `busAdOe` is 1. In every other state `ale` is 0.
- R2: In T1 of a memory transfer, `busHiOut` equals address bits 19..16. In T1 of an I/O transfer it is 0. `ioM` is 1 from T1 to T4 of an I/O transfer and 0 otherwise.
- R3: From T2 to T4, `busHiOut` is {0, ie, seg}. Bit 3 is always 0. Bit 2 is `intEnable` as registered at the clock edge that started the state. Bits 1..0 are the tag: 00 alternate data, 01 stack, 10 code/none, 11 data.
- R4: The lane code {`bheN`, `busAdOut[0]` in T1} is 00 for a word at an even address, 01 for an odd address (byte, or the upper half of a word), and 10 for a byte at an even address. `bheN` keeps that value until T4.
- R5: On a read, `rdN` is 0 in T2, T3 and the wait states, and 1 elsewhere. `busAdOe` is 0 from T2 to T4 of a read. `rdN` and `wrN` are never low together.
- R6: On a write, `wrN` is 0 in T2, T3 and the wait states. `busAdOut` carries the write data with `busAdOe` at 1 from T2 to T4.
- R7: T3 and each wait state move to T4 only if `ready` is 1 at the closing clock edge. Otherwise a wait state follows, with the strobe kept asserted and `done` at 0.
- R8: On a read, `busAdIn` is captured at the clock edge that leaves T3 or the last wait state, and it appears on `rdData` from T4 on. `done` is 1 for the single T4 clock.
- R9: `holdReq` is granted only from idle or at the end of T4, and it takes precedence over a pending request. While `holdAck` is 1, `busAdOe`, `busHiOe` and `bheOe` are 0, both strobes are 1 and `reqAccept` is 0.
- R10: `reqAccept` is 1 when `reqValid` is 1, `holdReq` is 0 and the machine is in idle or T4. The next clock is then T1, so back-to-back transfers have no idle clock between them.
- R11: During and right after reset, all output enables, `ale`, `done` and `holdAck` are 0, and `rdN` and `wrN` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Transfer request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O space, 0 = memory |
| reqWord | input | 1 | 1 = 16-bit transfer, 0 = byte |
| reqAddr | input | 20 | Transfer address |
| reqSeg | input | 2 | Segment-class tag |
| reqWdata | input | 16 | Write data |
| intEnable | input | 1 | Interrupt-enable flag shown in status |
| ready | input | 1 | Device ready, ends T3 or a wait state |
| holdReq | input | 1 | External master asks for the bus |
| busAdIn | input | 16 | Data sampled from the shared low lines |
| reqAccept | output | 1 | Request taken this clock |
| busAdOut | output | 16 | Address or write data for the low lines |
| busAdOe | output | 1 | Output enable of the low lines |
| busHiOut | output | 4 | Address bits 19..16 or status |
| busHiOe | output | 1 | Output enable of the top lines |
| bheN | output | 1 | Active-low high-byte enable |
| bheOe | output | 1 | Output enable of `bheN` |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| ioM | output | 1 | 1 during an I/O transfer |
| holdAck | output | 1 | Bus granted to the external master |
| done | output | 1 | Transfer completes (T4) |
| rdData | output | 16 | Captured read data |

## Verification
Each state lasts one clock, so the bench drives a request at a falling edge and expects the T1 outputs one falling edge later. T2 follows a clock after that, and T3 a clock after T2. T4 comes one clock after the first wait-type state in which the bench set `ready` high, and the captured read data is checked in that same T4 clock. `reqAccept` is combinational and is checked in the clock the request is presented. A hold grant is checked one clock after idle or T4. Inputs change only at the falling edge, and outputs are sampled 1 ns later, so every check falls inside the state it describes.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5,
    PH_HOLD = 3'd6
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // take the request fields
    logic capture;     // sample read data
    logic addrPhase;   // T1
    logic statusPhase; // T2..T4 including waits
    logic rdOn;
    logic wrOn;
  } ctl_t;
endpackage

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mux_bus_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic ready,
  input  logic holdReq,
  input  logic curWrite,
  output ctl_t ctl,
  output logic reqAccept,
  output logic holdAck,
  output logic done
);
  phase_t phase, phaseNext;
  logic   atBoundary;
  logic   strobeWindow;

  assign atBoundary   = (phase == PH_IDLE) || (phase == PH_T4);
  assign reqAccept    = atBoundary && !holdReq && reqValid;
  assign strobeWindow = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE, PH_T4: begin
        if (holdReq)       phaseNext = PH_HOLD;
        else if (reqValid) phaseNext = PH_T1;
        else               phaseNext = PH_IDLE;
      end
      PH_T1:   phaseNext = PH_T2;
      PH_T2:   phaseNext = PH_T3;
      PH_T3,
      PH_TW:   phaseNext = ready ? PH_T4 : PH_TW;
      PH_HOLD: phaseNext = holdReq ? PH_HOLD : PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    ctl.load        = reqAccept;
    ctl.capture     = ((phase == PH_T3) || (phase == PH_TW)) && ready && !curWrite;
    ctl.addrPhase   = (phase == PH_T1);
    ctl.statusPhase = strobeWindow || (phase == PH_T4);
    ctl.rdOn        = strobeWindow && !curWrite;
    ctl.wrOn        = strobeWindow && curWrite;
  end

  assign holdAck = (phase == PH_HOLD);
  assign done    = (phase == PH_T4);
endmodule

// File: rtl/mux_bus_dp.sv
module mux_bus_dp
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              intEnable,
  input  logic [DATA_W-1:0] busAdIn,
  output logic              curWrite,
  output logic [DATA_W-1:0] busAdOut,
  output logic              busAdOe,
  output logic [ADDR_W-DATA_W-1:0] busHiOut,
  output logic              busHiOe,
  output logic              bheN,
  output logic              bheOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              ioM,
  output logic [DATA_W-1:0] rdData
);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int PAD_W = HI_W - SEG_W - 1;

  logic [ADDR_W-1:0] addrQ;
  logic [SEG_W-1:0]  segQ;
  logic [DATA_W-1:0] wdataQ;
  logic              ioQ, wordQ, ieQ;
  logic              active;
  logic [HI_W-1:0]   hiAddr, hiStatus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      segQ     <= '0;
      wdataQ   <= '0;
      ioQ      <= 1'b0;
      wordQ    <= 1'b0;
      curWrite <= 1'b0;
    end else if (ctl.load) begin
      addrQ    <= reqAddr;
      segQ     <= reqSeg;
      wdataQ   <= reqWdata;
      ioQ      <= reqIo;
      wordQ    <= reqWord;
      curWrite <= reqWrite;
    end
  end

  // interrupt-enable status bit refreshed on every clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ieQ <= 1'b0;
    else       ieQ <= intEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (ctl.capture) rdData <= busAdIn;
  end

  assign active   = ctl.addrPhase || ctl.statusPhase;
  assign hiAddr   = ioQ ? '0 : addrQ[ADDR_W-1:DATA_W];
  assign hiStatus = {{PAD_W{1'b0}}, ieQ, segQ};

  always_comb begin
    if (ctl.addrPhase)                    busAdOut = addrQ[DATA_W-1:0];
    else if (ctl.statusPhase && curWrite) busAdOut = wdataQ;
    else                                  busAdOut = '0;
  end

  always_comb begin
    if (ctl.addrPhase)        busHiOut = hiAddr;
    else if (ctl.statusPhase) busHiOut = hiStatus;
    else                      busHiOut = '0;
  end

  assign busAdOe = ctl.addrPhase || (ctl.statusPhase && curWrite);
  assign busHiOe = active;
  assign bheOe   = active;
  assign bheN    = active ? !(wordQ || addrQ[0]) : 1'b1;
  assign ale     = ctl.addrPhase;
  assign rdN     = !ctl.rdOn;
  assign wrN     = !ctl.wrOn;
  assign ioM     = active && ioQ;
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              intEnable,
  input  logic              ready,
  input  logic              holdReq,
  input  logic [DATA_W-1:0] busAdIn,
  output logic              reqAccept,
  output logic [DATA_W-1:0] busAdOut,
  output logic              busAdOe,
  output logic [ADDR_W-DATA_W-1:0] busHiOut,
  output logic              busHiOe,
  output logic              bheN,
  output logic              bheOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              ioM,
  output logic              holdAck,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);
  ctl_t ctl;
  logic curWrite;

  mux_bus_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .ready     (ready),
    .holdReq   (holdReq),
    .curWrite  (curWrite),
    .ctl       (ctl),
    .reqAccept (reqAccept),
    .holdAck   (holdAck),
    .done      (done)
  );

  mux_bus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqWrite  (reqWrite),
    .reqIo     (reqIo),
    .reqWord   (reqWord),
    .reqAddr   (reqAddr),
    .reqSeg    (reqSeg),
    .reqWdata  (reqWdata),
    .intEnable (intEnable),
    .busAdIn   (busAdIn),
    .curWrite  (curWrite),
    .busAdOut  (busAdOut),
    .busAdOe   (busAdOe),
    .busHiOut  (busHiOut),
    .busHiOe   (busHiOe),
    .bheN      (bheN),
    .bheOe     (bheOe),
    .ale       (ale),
    .rdN       (rdN),
    .wrN       (wrN),
    .ioM       (ioM),
    .rdData    (rdData)
  );
endmodule

// File: rtl/mux_bus_chk.sv
module mux_bus_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic clk,
  input logic rstN,
  input logic ready,
  input logic [ADDR_W-DATA_W-1:0] busHiOut,
  input logic busAdOe,
  input logic busHiOe,
  input logic bheOe,
  input logic ale,
  input logic rdN,
  input logic wrN,
  input logic ioM,
  input logic holdAck,
  input logic done
);
  localparam int HI_W = ADDR_W - DATA_W;

  p_ale_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  p_ale_drives_r1: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (busAdOe && rdN && wrN));
  p_io_hi_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ale && ioM) |-> (busHiOut == '0));
  p_s6_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busHiOe && !ale) |-> !busHiOut[HI_W-1]);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  p_done_after_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(ready));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_hold_released_r9: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (!busAdOe && !busHiOe && !bheOe && rdN && wrN && !ale));
  p_hold_boundary_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> ($past(done) || $past(!busHiOe)));
endmodule

bind mux_bus_seq mux_bus_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ready    (ready),
  .busHiOut (busHiOut),
  .busAdOe  (busAdOe),
  .busHiOe  (busHiOe),
  .bheOe    (bheOe),
  .ale      (ale),
  .rdN      (rdN),
  .wrN      (wrN),
  .ioM      (ioM),
  .holdAck  (holdAck),
  .done     (done)
);

// File: tb/sim_mux_bus_seq.sv
`timescale 1ns/1ps
module sim_mux_bus_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqIo = 1'b0, reqWord = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [1:0]  reqSeg = '0;
  logic [15:0] reqWdata = '0;
  logic        intEnable = 1'b0, ready = 1'b0, holdReq = 1'b0;
  logic [15:0] busAdIn = '0;
  logic        reqAccept, busAdOe, busHiOe, bheN, bheOe, ale, rdN, wrN, ioM, holdAck, done;
  logic [15:0] busAdOut, rdData;
  logic [3:0]  busHiOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mux_bus_seq u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] expHi(input logic [19:0] a, input bit io);
    return io ? 4'h0 : a[19:16];
  endfunction

  function automatic logic [1:0] expLane(input bit word, input logic [19:0] a);
    if (a[0])  return 2'b01;
    if (word)  return 2'b00;
    return 2'b10;
  endfunction

  function automatic logic [3:0] expStatus(input bit ie, input logic [1:0] sg);
    return {1'b0, ie, sg};
  endfunction

  // presents a request at the current falling edge and runs it to T4
  task automatic busCycle(input bit wr, input bit io, input bit word,
                          input logic [19:0] a, input logic [1:0] sg,
                          input logic [15:0] wd, input int waits,
                          input logic [15:0] rv, input bit ie);
    reqValid = 1; reqWrite = wr; reqIo = io; reqWord = word;
    reqAddr = a; reqSeg = sg; reqWdata = wd; intEnable = ie; ready = 0;
    #1;
    chk(reqAccept === 1'b1, "R10", "accept", reqAccept, 1);
    @(negedge clk); reqValid = 0; #1;
    // T1
    chk(ale === 1'b1, "R1", "ale in T1", ale, 1);
    chk(busAdOut === a[15:0] && busAdOe === 1'b1, "R1", "address low", busAdOut, a[15:0]);
    chk(busHiOut === expHi(a, io), "R2", "address high", busHiOut, expHi(a, io));
    chk(ioM === io, "R2", "ioM", ioM, io);
    chk({bheN, busAdOut[0]} === expLane(word, a), "R4", "lane code", {bheN, busAdOut[0]}, expLane(word, a));
    @(negedge clk); #1;
    // T2
    chk(ale === 1'b0, "R1", "ale after T1", ale, 0);
    chk(busHiOut === expStatus(ie, sg), "R3", "status nibble", busHiOut, expStatus(ie, sg));
    chk(bheN === expLane(word, a)[1], "R4", "bheN held", bheN, expLane(word, a)[1]);
    chk(rdN === wr, "R5", "rdN in T2", rdN, wr);
    chk(wrN === !wr, "R6", "wrN in T2", wrN, !wr);
    chk(busAdOe === wr, "R5", "low lines enable in T2", busAdOe, wr);
    if (wr) chk(busAdOut === wd, "R6", "write data", busAdOut, wd);
    busAdIn = rv;
    for (int k = 0; k <= waits; k++) begin
      @(negedge clk); #1;
      ready = (k == waits);
      chk(rdN === wr && wrN === !wr, "R7", "strobe held", {rdN, wrN}, {wr, !wr});
      chk(done === 1'b0, "R7", "no done while waiting", done, 0);
      chk(busHiOut === expStatus(ie, sg), "R3", "status in wait", busHiOut, expStatus(ie, sg));
    end
    @(negedge clk); #1;
    // T4
    ready = 0;
    chk(done === 1'b1, "R8", "done in T4", done, 1);
    chk(rdN === 1'b1 && wrN === 1'b1, "R5", "strobes off in T4", {rdN, wrN}, 2'b11);
    if (!wr) chk(rdData === rv, "R8", "read capture", rdData, rv);
    else     chk(busAdOut === wd && busAdOe === 1'b1, "R6", "write data in T4", busAdOut, wd);
  endtask

  task automatic idleCycles(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      chk(done === 1'b0 && ale === 1'b0 && busHiOe === 1'b0, "R10", "idle outputs",
          {done, ale, busHiOe}, 0);
    end
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(busAdOe === 0 && busHiOe === 0 && bheOe === 0 && ale === 0 && done === 0 && holdAck === 0
        && rdN === 1 && wrN === 1, "R11", "reset state",
        {busAdOe, busHiOe, bheOe, ale, done, holdAck, rdN, wrN}, 8'b00000011);
    rstN = 1;
    @(negedge clk); #1;
    chk(busAdOe === 0 && rdN === 1 && wrN === 1 && holdAck === 0, "R11", "after reset",
        {busAdOe, rdN, wrN, holdAck}, 4'b0110);

    // directed: each lane code and segment tag
    busCycle(0, 0, 1, 20'hA1234, 2'b00, 16'h0, 0, 16'hBEEF, 1);   // word even
    idleCycles(1);
    busCycle(1, 0, 0, 20'h5F001, 2'b01, 16'h3C3C, 1, 16'h0, 0);   // byte odd
    idleCycles(1);
    busCycle(0, 0, 0, 20'hC0F02, 2'b10, 16'h0, 3, 16'h1357, 1);   // byte even, 3 waits
    busCycle(1, 1, 1, 20'hF0080, 2'b11, 16'hA5A5, 0, 16'h0, 1);   // I/O write back-to-back
    busCycle(0, 1, 1, 20'h9FFF3, 2'b00, 16'h0, 2, 16'h2468, 0);   // I/O word odd address
    idleCycles(2);

    // R9: hold in idle beats a pending request
    holdReq = 1; reqValid = 1; #1;
    chk(reqAccept === 1'b0, "R9", "no accept under hold", reqAccept, 0);
    @(negedge clk); #1;
    chk(holdAck === 1'b1, "R9", "hold granted from idle", holdAck, 1);
    chk(busAdOe === 0 && busHiOe === 0 && bheOe === 0 && rdN === 1 && wrN === 1, "R9",
        "pins released", {busAdOe, busHiOe, bheOe, rdN, wrN}, 5'b00011);
    chk(reqAccept === 1'b0, "R9", "no accept in hold", reqAccept, 0);
    holdReq = 0; reqValid = 0;
    @(negedge clk); #1;
    chk(holdAck === 1'b0, "R9", "hold dropped", holdAck, 0);

    // R9: hold raised mid-transfer waits for T4
    fork
      busCycle(0, 0, 1, 20'h12340, 2'b11, 16'h0, 1, 16'h7777, 1);
      begin
        @(negedge clk); holdReq = 1;
        @(negedge clk); #1;
        chk(holdAck === 1'b0, "R9", "no grant inside transfer", holdAck, 0);
      end
    join
    reqValid = 1; #1;
    chk(reqAccept === 1'b0, "R9", "hold wins at T4", reqAccept, 0);
    @(negedge clk); #1;
    chk(holdAck === 1'b1, "R9", "grant after T4", holdAck, 1);
    reqValid = 0; holdReq = 0;
    @(negedge clk); #1;

    // random transfers
    for (int n = 0; n < 60; n++) begin
      logic [19:0] a;
      a = 20'($urandom);
      busCycle(1'($urandom), 1'($urandom), 1'($urandom), a, 2'($urandom),
               16'($urandom), int'($urandom % 4), 16'($urandom), 1'($urandom));
      idleCycles(int'($urandom % 3));
    end
    finishRun();
  end
endmodule